// File: doc/BRIEF.md
# Level-to-Edge Interrupt Merger

This block takes a set of level-sensitive interrupt requests from on-board peripherals and merges them into a single request line. That line feeds an edge-triggered non-maskable interrupt input on a processor. Each request stays high until its peripheral has been serviced. There is no vector number and no acknowledge handshake. The handler reads a status register to find out which sources are active.

The output is gated by two control bits and by a per-source enable register. The global enable bit lets the line rise at all. The hold-off bit forces the line low while it is set, and the handler sets it at entry and clears it at exit. If an enabled request is still high when the hold-off bit is cleared, the line rises again. The edge-only input therefore sees a new edge for every request that is still pending.

The registers sit on a simple 8-bit bus with a 2-bit address. A write takes effect at the rising clock edge on which the write strobe is high. Reads are combinational from the address.

Top module: `irq_edge_merge`

## Requirements
- R1: After reset, CONTROL (address 0) reads 0x02, which means global enable 0 and hold-off 1. ENABLE (address 1) reads 0x00, and `nmi_out` is low.
- R2: `nmi_out` is a registered copy of: global enable AND NOT hold-off AND (OR over sources of enable bit AND synchronized level). When enabled, a source going high drives `nmi_out` high on the third rising edge that samples it.
- R3: While CONTROL bit 0 (global enable) is 0, `nmi_out` stays low whatever the sources and enables are.
- R4: While CONTROL bit 1 (hold-off) is 1, `nmi_out` stays low.
- R5: The case is a write that clears the hold-off bit while an enabled source is high and global enable is 1. `nmi_out` rises on the rising edge after the write edge, and it does so on every such unmask.
- R6: Clearing the hold-off bit with no enabled source pending leaves `nmi_out` low. A later assertion of an enabled source then raises it with the R2 latency.
- R7: STATUS (address 2) shows the synchronized raw level of every source, bit i for source i, regardless of the enables. A change appears two rising edges after the input changes.
- R8: Writes to address 2 or address 3 change neither CONTROL, ENABLE nor `nmi_out`. Address 3 reads 0x00.
- R9: A source whose ENABLE bit (bit i for source i) is 0 cannot raise `nmi_out`.
- R10: CONTROL reads back the written bit 0 (global enable) and bit 1 (hold-off). Bits 7:2 read 0. ENABLE reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | N_SRC | Level interrupt requests, asynchronous |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| nmi_out | output | 1 | Merged request to the edge-triggered input |

## Verification
A source change reaches STATUS after two rising edges and `nmi_out` after three. A CONTROL or ENABLE write edge moves `nmi_out` one edge later. The bench drives inputs on falling edges and counts rising edges to the exact edge each result is due. For the latency and unmask cases it checks the value one edge before the due edge as well as at it. The table sweep waits four cycles after each input change before sampling, and it does so on falling edges.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
    localparam int CTRL_GINT_BIT = 0;
    localparam int CTRL_HOLD_BIT = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raw,
    output logic [N_SRC-1:0] synced
);
    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced = st_q.s2;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_merge_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N_SRC-1:0]  lvl_sync,
    output logic              gint,
    output logic              hold,
    output logic [N_SRC-1:0]  enable,
    output logic [DATA_W-1:0] reg_rdata
);
    typedef struct packed {
        logic             gint;
        logic             hold;
        logic [N_SRC-1:0] en;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    rg_d.gint = reg_wdata[CTRL_GINT_BIT];
                    rg_d.hold = reg_wdata[CTRL_HOLD_BIT];
                end
                A_ENABLE: rg_d.en = reg_wdata[N_SRC-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.gint <= 1'b0;
            rg_q.hold <= 1'b1;
            rg_q.en   <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_GINT_BIT] = rg_q.gint;
                reg_rdata[CTRL_HOLD_BIT] = rg_q.hold;
            end
            A_ENABLE: reg_rdata[N_SRC-1:0] = rg_q.en;
            A_STATUS: reg_rdata[N_SRC-1:0] = lvl_sync;
            default: reg_rdata = '0;
        endcase
    end

    assign gint   = rg_q.gint;
    assign hold   = rg_q.hold;
    assign enable = rg_q.en;
endmodule

// File: rtl/irq_out.sv
module irq_out #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gint,
    input  logic             hold,
    input  logic [N_SRC-1:0] enable,
    input  logic [N_SRC-1:0] lvl_sync,
    output logic             nmi
);
    typedef struct packed {
        logic line;
    } out_t;

    out_t o_d, o_q;
    logic [N_SRC-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < N_SRC; i++) begin : g_hit
            assign hit[i] = enable[i] & lvl_sync[i];
        end
    endgenerate

    always_comb begin
        o_d      = o_q;
        o_d.line = gint & ~hold & (|hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign nmi = o_q.line;
endmodule

// File: rtl/irq_edge_merge.sv
module irq_edge_merge
    import irq_merge_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_lvl,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              nmi_out
);
    logic [N_SRC-1:0] lvl_w;
    logic [N_SRC-1:0] en_w;
    logic             gint_w;
    logic             hold_w;

    irq_sync #(.N_SRC(N_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(src_lvl), .synced(lvl_w)
    );

    irq_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .lvl_sync(lvl_w), .gint(gint_w),
        .hold(hold_w), .enable(en_w), .reg_rdata(reg_rdata)
    );

    irq_out #(.N_SRC(N_SRC)) u_out (
        .clk(clk), .rst_n(rst_n), .gint(gint_w), .hold(hold_w),
        .enable(en_w), .lvl_sync(lvl_w), .nmi(nmi_out)
    );
endmodule

// File: rtl/irq_edge_merge_chk.sv
module irq_edge_merge_chk #(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              nmi_out,
    input logic              gint,
    input logic              hold,
    input logic [N_SRC-1:0]  en,
    input logic [N_SRC-1:0]  lvl
);
    p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gint && !hold && |(en & lvl)) |=> nmi_out);

    p_gint_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gint |=> !nmi_out);

    p_hold_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !nmi_out);

    p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold) && gint && |(en & lvl)) |=> $rose(nmi_out));

    p_status_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) |-> (reg_rdata[N_SRC-1:0] == lvl));

    p_ro_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[1]) |=> ($stable(gint) && $stable(hold) && $stable(en)));
endmodule

bind irq_edge_merge irq_edge_merge_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .nmi_out(nmi_out), .gint(gint_w), .hold(hold_w),
    .en(en_w), .lvl(lvl_w)
);

// File: tb/tb_irq_edge_merge.sv
`timescale 1ns/1ps
module tb_irq_edge_merge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_lvl = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       nmi_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_edge_merge dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nmi_out(nmi_out)
    );

    typedef struct packed {
        logic [1:0] ctrl;
        logic [7:0] en;
        logic [7:0] src;
        logic       nmi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{ctrl: 2'b01, en: 8'hFF, src: 8'h01, nmi: 1'b1},
        '{ctrl: 2'b01, en: 8'h00, src: 8'hFF, nmi: 1'b0},
        '{ctrl: 2'b00, en: 8'hFF, src: 8'hFF, nmi: 1'b0},
        '{ctrl: 2'b11, en: 8'hFF, src: 8'hFF, nmi: 1'b0},
        '{ctrl: 2'b01, en: 8'h80, src: 8'h80, nmi: 1'b1},
        '{ctrl: 2'b01, en: 8'h0F, src: 8'hF0, nmi: 1'b0},
        '{ctrl: 2'b01, en: 8'h0F, src: 8'h18, nmi: 1'b1},
        '{ctrl: 2'b01, en: 8'hAA, src: 8'h55, nmi: 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [7:0] d;
        cyc(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 control", d, 8'h02);
        rd(2'd1, d); chk("R1 enable", d, 8'h00);
        @(negedge clk); chk("R1 nmi", {7'b0, nmi_out}, 8'h00);

        // Table sweep: R2 R3 R4 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, 8'h02);
            src_lvl = '0;
            cyc(4);
            wr(2'd1, VECS[v].en);
            @(negedge clk) src_lvl = VECS[v].src;
            wr(2'd0, {6'b0, VECS[v].ctrl});
            cyc(4);
            @(negedge clk);
            chk($sformatf("R2/R3/R4/R9 vec%0d nmi", v), {7'b0, nmi_out}, {7'b0, VECS[v].nmi});
            rd(2'd2, d); chk($sformatf("R7 vec%0d status", v), d, VECS[v].src);
            rd(2'd0, d); chk($sformatf("R10 vec%0d control", v), d, {6'b0, VECS[v].ctrl});
            rd(2'd1, d); chk($sformatf("R10 vec%0d enable", v), d, VECS[v].en);
        end

        // R2 and R7 latency
        wr(2'd0, 8'h02); src_lvl = '0;
        wr(2'd1, 8'h04);
        wr(2'd0, 8'h01);
        cyc(4);
        @(negedge clk) src_lvl = 8'h04;
        @(posedge clk);
        #1 reg_addr = 2'd2;
        @(negedge clk); chk("R7 status after 1 edge", reg_rdata, 8'h00);
        @(posedge clk);
        @(negedge clk); chk("R7 status after 2 edges", reg_rdata, 8'h04);
        chk("R2 nmi after 2 edges", {7'b0, nmi_out}, 8'h00);
        @(posedge clk);
        @(negedge clk); chk("R2 nmi after 3 edges", {7'b0, nmi_out}, 8'h01);

        // R5 unmask with pending source
        wr(2'd0, 8'h03);
        @(negedge clk); chk("R4 nmi one edge after hold", {7'b0, nmi_out}, 8'h01);
        @(posedge clk); @(negedge clk);
        chk("R4 nmi low under hold", {7'b0, nmi_out}, 8'h00);
        cyc(2);
        for (int r = 0; r < 2; r++) begin
            wr(2'd0, 8'h01);
            @(negedge clk); chk("R5 nmi at write edge", {7'b0, nmi_out}, 8'h00);
            @(posedge clk); @(negedge clk);
            chk("R5 nmi rises after unmask", {7'b0, nmi_out}, 8'h01);
            wr(2'd0, 8'h03);
            cyc(2);
        end

        // R8 writes to STATUS and address 3 ignored (hold=1, gint=1, en=04)
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFC);
        rd(2'd0, d); chk("R8 control unchanged", d, 8'h03);
        rd(2'd1, d); chk("R8 enable unchanged", d, 8'h04);
        rd(2'd3, d); chk("R8 addr3 reads zero", d, 8'h00);
        cyc(2);
        @(negedge clk); chk("R8 nmi unchanged", {7'b0, nmi_out}, 8'h00);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h00);
        cyc(2);
        @(negedge clk); chk("R8 nmi stays high", {7'b0, nmi_out}, 8'h01);

        // R6 unmask with nothing pending
        wr(2'd0, 8'h03);
        @(negedge clk) src_lvl = 8'h00;
        cyc(4);
        wr(2'd0, 8'h01);
        cyc(4);
        @(negedge clk); chk("R6 nmi low with nothing pending", {7'b0, nmi_out}, 8'h00);
        src_lvl = 8'h04;
        @(posedge clk); @(posedge clk);
        @(negedge clk); chk("R6 nmi before due edge", {7'b0, nmi_out}, 8'h00);
        @(posedge clk);
        @(negedge clk); chk("R6 nmi after source asserts", {7'b0, nmi_out}, 8'h01);

        summary();
    end
endmodule